// File: doc/BRIEF.md
# Floating-Point Exception Status Word Unit

This block holds the 16-bit status word of a stack-based floating-point unit and keeps it up to date as the arithmetic datapath reports exception events. Each cycle the datapath may present any combination of six exception events, a stack-fault indication with its overflow/underflow direction bit, and an internal-error strobe. The block records every reported exception in sticky flags. It maintains the four condition codes and the stack-top pointer, and it derives the error-summary and busy bits by comparing the sticky flags with the mask bits of the control word supplied by the surrounding unit.

A registered interrupt-pending output rises when an unmasked exception becomes present and stays high until software issues a clear. The clear input empties the flags in a single cycle and leaves the stack-top field and the condition codes as they were. All state changes happen on the rising clock edge, and a synchronous active-high reset loads zero.

Top module: `fpu_exc_status_unit`

## Requirements
- R1: A synchronous reset drives `status_word` to 0x0000 and `irq_pend` to 0 after the next rising edge.
- R2: The exception flag bits sit at status bits 0 (invalid), 1 (denormal), 2 (zero-divide), 3 (overflow), 4 (underflow) and 5 (precision). A 1 on `exc_evt[i]` sets status bit i at the next edge, and the bit then stays set until a clear.
- R3: Status bit 7 (summary) and bit 15 (busy) are 1 exactly when some set flag bit i has `ctrl_word[i]` = 0, or when an internal error has been recorded since the last clear. They follow `ctrl_word` in the same cycle.
- R4: A stack fault sets status bit 6 (stack fault) and status bit 0 (invalid) at the next edge.
- R5: In a cycle with a stack fault or a precision event (`exc_evt[5]`), status bit 9 (C1) takes the value of `c1_dir`. In any other cycle without a condition-code write, C1 holds its value.
- R6: `cc_we` loads C3 (bit 14), C2 (bit 10), C1 (bit 9) and C0 (bit 8) from `cc_in[3:0]` in that order. A simultaneous C1 rule from R5 takes priority for C1.
- R7: `top_we` loads `top_in` into status bits 13:11.
- R8: `int_err` sets all six flags and forces the summary and busy bits to 1 whatever the masks are.
- R9: `clr_exc` clears the six flags, the stack-fault bit, the recorded internal error, summary, busy and `irq_pend` in one cycle, and leaves bits 14:8 unchanged. Events presented in the same cycle are recorded after the clear.
- R10: `irq_pend` rises on the edge at which an unmasked flag or an internal error becomes present. It then stays at 1 until a clear, even if the masks are set again afterwards.
- R11: `ctrl_word` bits 15:6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exc_evt | input | 6 | Exception events for this cycle, one bit per flag position |
| stk_fault | input | 1 | Stack fault reported this cycle |
| c1_dir | input | 1 | Direction bit carried by a stack-fault or precision event |
| int_err | input | 1 | Internal-error strobe |
| clr_exc | input | 1 | Clear exception state |
| ctrl_word | input | 16 | Control word; bits 5:0 are the exception masks |
| cc_we | input | 1 | Condition-code write enable |
| cc_in | input | 4 | New C3, C2, C1, C0 |
| top_we | input | 1 | Stack-top write enable |
| top_in | input | 3 | New stack-top pointer |
| status_word | output | 16 | Assembled status word |
| irq_pend | output | 1 | Unmasked exception pending |

## Verification
The bench unmasks a flag that was already set and then masks it again. A design that registered the summary, or that let the interrupt follow the summary, would lag or drop `irq_pend`. It drives a clear together with a new event, which shows whether events are lost or whether the clear also wipes the condition codes and stack top. It drives a condition-code write in the same cycle as a stack fault whose direction bit differs from the written C1, which catches the wrong priority. It also raises an internal error with every mask set, so a design that derived summary only from the masks would leave bit 7 low.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
   localparam int SW_W      = 16;
   localparam int NUM_EXC   = 6;
   localparam int CC_W      = 4;
   localparam int POS_IE    = 0;
   localparam int POS_PE    = 5;
   localparam int POS_SF    = 6;
   localparam int POS_ES    = 7;
   localparam int POS_C0    = 8;
   localparam int POS_C1    = 9;
   localparam int POS_C2    = 10;
   localparam int POS_TOP   = 11;
   localparam int POS_C3    = 14;
   localparam int POS_BUSY  = 15;
   localparam int CC_IDX_C1 = 1;
endpackage

// File: rtl/fxs_flag_bank.sv
module fxs_flag_bank #(
   parameter int NUM_EXC = 6,
   parameter int IE_IDX  = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clr,
   input  logic [NUM_EXC-1:0] evt,
   input  logic               stk_fault,
   input  logic               int_err,
   output logic [NUM_EXC-1:0] flags_q,
   output logic [NUM_EXC-1:0] flags_nx,
   output logic               sf_q,
   output logic               force_q,
   output logic               force_nx
);
   logic sf_nx;

   for (genvar i = 0; i < NUM_EXC; i++) begin : g_flag
      logic from_stack;
      if (i == IE_IDX) begin : g_ie
         assign from_stack = stk_fault;
      end else begin : g_other
         assign from_stack = 1'b0;
      end
      always_comb flags_nx[i] = (flags_q[i] & ~clr) | evt[i] | int_err | from_stack;
      always_ff @(posedge clk) begin
         if (rst) flags_q[i] <= 1'b0;
         else     flags_q[i] <= flags_nx[i];
      end
   end

   always_comb begin
      sf_nx    = (sf_q & ~clr) | stk_fault;
      force_nx = (force_q & ~clr) | int_err;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sf_q    <= 1'b0;
         force_q <= 1'b0;
      end else begin
         sf_q    <= sf_nx;
         force_q <= force_nx;
      end
   end
endmodule

// File: rtl/fxs_cond_codes.sv
module fxs_cond_codes #(
   parameter int CC_W   = 4,
   parameter int TOP_W  = 3,
   parameter int C1_IDX = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cc_we,
   input  logic [CC_W-1:0]  cc_in,
   input  logic             c1_force,
   input  logic             c1_dir,
   input  logic             top_we,
   input  logic [TOP_W-1:0] top_in,
   output logic [CC_W-1:0]  cc_q,
   output logic [TOP_W-1:0] top_q
);
   logic [CC_W-1:0] cc_nx;

   always_comb begin
      cc_nx = cc_we ? cc_in : cc_q;
      if (c1_force) cc_nx[C1_IDX] = c1_dir;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cc_q  <= '0;
         top_q <= '0;
      end else begin
         cc_q <= cc_nx;
         if (top_we) top_q <= top_in;
      end
   end
endmodule

// File: rtl/fxs_summary.sv
module fxs_summary #(
   parameter int NUM_EXC    = 6,
   parameter bit IRQ_STICKY = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clr,
   input  logic [NUM_EXC-1:0] flags_q,
   input  logic [NUM_EXC-1:0] flags_nx,
   input  logic               force_q,
   input  logic               force_nx,
   input  logic [NUM_EXC-1:0] mask,
   output logic               es,
   output logic               irq_q
);
   logic es_nx;
   logic irq_nx;

   always_comb begin
      es    = force_q  | (|(flags_q  & ~mask));
      es_nx = force_nx | (|(flags_nx & ~mask));
   end

   if (IRQ_STICKY) begin : g_sticky
      always_comb irq_nx = (irq_q & ~clr) | es_nx;
   end else begin : g_follow
      always_comb irq_nx = es_nx;
   end

   always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= irq_nx;
   end
endmodule

// File: rtl/fpu_exc_status_unit.sv
module fpu_exc_status_unit
   import fxs_pkg::*;
#(
   parameter int TOP_W      = 3,
   parameter bit IRQ_STICKY = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [5:0]  exc_evt,
   input  logic        stk_fault,
   input  logic        c1_dir,
   input  logic        int_err,
   input  logic        clr_exc,
   input  logic [15:0] ctrl_word,
   input  logic        cc_we,
   input  logic [3:0]  cc_in,
   input  logic        top_we,
   input  logic [2:0]  top_in,
   output logic [15:0] status_word,
   output logic        irq_pend
);
   if (TOP_W != POS_C3 - POS_TOP) begin : g_bad_top
      $error("TOP_W must fill the field between the stack-top base and C3");
   end
   if (NUM_EXC != POS_SF) begin : g_bad_exc
      $error("exception flags must end just below the stack-fault bit");
   end

   logic [NUM_EXC-1:0] flags_q, flags_nx;
   logic               sf_q, force_q, force_nx, es;
   logic [CC_W-1:0]    cc_q;
   logic [TOP_W-1:0]   top_q;
   logic               unused_ctrl;

   assign unused_ctrl = ^ctrl_word[SW_W-1:NUM_EXC];

   fxs_flag_bank #(.NUM_EXC(NUM_EXC), .IE_IDX(POS_IE)) u_flags (
      .clk(clk), .rst(rst), .clr(clr_exc), .evt(exc_evt),
      .stk_fault(stk_fault), .int_err(int_err),
      .flags_q(flags_q), .flags_nx(flags_nx), .sf_q(sf_q),
      .force_q(force_q), .force_nx(force_nx)
   );

   fxs_cond_codes #(.CC_W(CC_W), .TOP_W(TOP_W), .C1_IDX(CC_IDX_C1)) u_cc (
      .clk(clk), .rst(rst), .cc_we(cc_we), .cc_in(cc_in),
      .c1_force(stk_fault | exc_evt[POS_PE]), .c1_dir(c1_dir),
      .top_we(top_we), .top_in(top_in), .cc_q(cc_q), .top_q(top_q)
   );

   fxs_summary #(.NUM_EXC(NUM_EXC), .IRQ_STICKY(IRQ_STICKY)) u_sum (
      .clk(clk), .rst(rst), .clr(clr_exc),
      .flags_q(flags_q), .flags_nx(flags_nx),
      .force_q(force_q), .force_nx(force_nx),
      .mask(ctrl_word[NUM_EXC-1:0]), .es(es), .irq_q(irq_pend)
   );

   always_comb begin
      status_word                         = '0;
      status_word[NUM_EXC-1:0]            = flags_q;
      status_word[POS_SF]                 = sf_q;
      status_word[POS_ES]                 = es;
      status_word[POS_C0]                 = cc_q[0];
      status_word[POS_C1]                 = cc_q[1];
      status_word[POS_C2]                 = cc_q[2];
      status_word[POS_TOP+TOP_W-1:POS_TOP] = top_q;
      status_word[POS_C3]                 = cc_q[3];
      status_word[POS_BUSY]               = es;
   end
endmodule

// File: rtl/fxs_checker.sv
module fxs_checker (
   input logic        clk,
   input logic        rst,
   input logic [5:0]  exc_evt,
   input logic        stk_fault,
   input logic        c1_dir,
   input logic        int_err,
   input logic        clr_exc,
   input logic [15:0] ctrl_word,
   input logic        top_we,
   input logic [2:0]  top_in,
   input logic [15:0] status_word,
   input logic        irq_pend
);
   a_r1_reset_zero: assert property (@(posedge clk)
      rst |=> (status_word == 16'h0000 && !irq_pend));

   a_r2_flags_sticky: assert property (@(posedge clk) disable iff (rst)
      !clr_exc |=> ((status_word[5:0] & $past(status_word[5:0])) == $past(status_word[5:0])));

   a_r3_unmasked_summary: assert property (@(posedge clk) disable iff (rst)
      ((status_word[5:0] & ~ctrl_word[5:0]) != 6'd0) |-> (status_word[7] && status_word[15]));

   a_r5_c1_direction: assert property (@(posedge clk) disable iff (rst)
      (stk_fault || exc_evt[5]) |=> (status_word[9] == $past(c1_dir)));

   a_r7_top_load: assert property (@(posedge clk) disable iff (rst)
      top_we |=> (status_word[13:11] == $past(top_in)));

   a_r8_internal_error: assert property (@(posedge clk) disable iff (rst)
      int_err |=> (status_word[5:0] == 6'h3f && status_word[7] && status_word[15]));

   a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
      (clr_exc && exc_evt == 6'd0 && !stk_fault && !int_err)
         |=> (status_word[7:0] == 8'h00 && !irq_pend));

   a_r10_irq_holds: assert property (@(posedge clk) disable iff (rst)
      (irq_pend && !clr_exc) |=> irq_pend);
endmodule

bind fpu_exc_status_unit fxs_checker u_fxs_chk (
   .clk(clk), .rst(rst), .exc_evt(exc_evt), .stk_fault(stk_fault),
   .c1_dir(c1_dir), .int_err(int_err), .clr_exc(clr_exc),
   .ctrl_word(ctrl_word), .top_we(top_we), .top_in(top_in),
   .status_word(status_word), .irq_pend(irq_pend)
);

// File: tb/fpu_exc_status_unit_tb_top.sv
`timescale 1ns/1ps
module fpu_exc_status_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  exc_evt = '0;
   logic        stk_fault = 1'b0, c1_dir = 1'b0, int_err = 1'b0, clr_exc = 1'b0;
   logic [15:0] ctrl_word = 16'h003f;
   logic        cc_we = 1'b0, top_we = 1'b0;
   logic [3:0]  cc_in = '0;
   logic [2:0]  top_in = '0;
   logic [15:0] status_word;
   logic        irq_pend;

   typedef struct {
      logic [15:0] sw;
      logic        irq;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   logic [5:0] m_flags;
   logic       m_sf, m_force, m_irq;
   logic [3:0] m_cc;
   logic [2:0] m_top;

   always #10 clk = ~clk;

   fpu_exc_status_unit dut_i (
      .clk(clk), .rst(rst), .exc_evt(exc_evt), .stk_fault(stk_fault),
      .c1_dir(c1_dir), .int_err(int_err), .clr_exc(clr_exc),
      .ctrl_word(ctrl_word), .cc_we(cc_we), .cc_in(cc_in),
      .top_we(top_we), .top_in(top_in),
      .status_word(status_word), .irq_pend(irq_pend)
   );

   function automatic exp_t model_out(input string tag);
      exp_t e;
      logic es;
      es = m_force | (|(m_flags & ~ctrl_word[5:0]));
      e.sw = {es, m_cc[3], m_top, m_cc[2], m_cc[1], m_cc[0], es, m_sf, m_flags};
      e.irq = m_irq;
      e.tag = tag;
      return e;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      exc_evt = '0; stk_fault = 0; int_err = 0; clr_exc = 0; cc_we = 0; top_we = 0;
      m_flags = '0; m_sf = 0; m_force = 0; m_irq = 0; m_cc = '0; m_top = '0;
      exp_q.push_back(model_out("R1 reset state"));
   endtask

   task automatic step(input logic [5:0] evt, input logic stk, input logic c1,
                       input logic ie, input logic clr, input logic [15:0] ctrl,
                       input logic ccw, input logic [3:0] ccv,
                       input logic tw, input logic [2:0] tv, input string tag);
      logic es;
      @(negedge clk);
      rst = 1'b0;
      exc_evt = evt; stk_fault = stk; c1_dir = c1; int_err = ie; clr_exc = clr;
      ctrl_word = ctrl; cc_we = ccw; cc_in = ccv; top_we = tw; top_in = tv;
      if (clr) begin
         m_flags = '0; m_sf = 0; m_force = 0; m_irq = 0;
      end
      m_flags = m_flags | evt | {5'd0, stk} | (ie ? 6'h3f : 6'h00);
      m_sf    = m_sf | stk;
      m_force = m_force | ie;
      if (ccw) m_cc = ccv;
      if (stk || evt[5]) m_cc[1] = c1;
      if (tw) m_top = tv;
      es = m_force | (|(m_flags & ~ctrl[5:0]));
      m_irq = m_irq | es;
      exp_q.push_back(model_out(tag));
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (status_word !== e.sw || irq_pend !== e.irq) begin
               n_bad++;
               $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                        e.tag, status_word, irq_pend, e.sw, e.irq);
            end
         end
      end
   end

   initial begin : driver
      do_reset();
      step(6'b000100, 0, 0, 0, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R2 masked zero-divide flag set");
      step(6'b000000, 0, 0, 0, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R2 flag sticky");
      step(6'b000000, 0, 0, 0, 0, 16'h003b, 0, 4'h0, 0, 3'd0, "R3 unmask gives summary and busy");
      step(6'b000000, 0, 0, 0, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R10 irq holds after remask");
      step(6'b000000, 0, 0, 0, 0, 16'hffff, 0, 4'h0, 0, 3'd0, "R11 upper control bits ignored");
      step(6'b000000, 0, 0, 0, 1, 16'h003f, 0, 4'h0, 0, 3'd0, "R9 clear empties flags");
      step(6'b000000, 0, 0, 0, 0, 16'h003f, 1, 4'b1011, 1, 3'd5, "R6 R7 cc and top load");
      step(6'b100000, 0, 1, 0, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R5 precision round-up keeps C1");
      step(6'b100000, 0, 0, 0, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R5 precision round-down clears C1");
      step(6'b001000, 0, 1, 0, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R5 overflow alone leaves C1");
      step(6'b000000, 1, 1, 0, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R4 stack fault sets SF IE C1");
      step(6'b000000, 0, 0, 0, 1, 16'h003f, 0, 4'h0, 0, 3'd0, "R9 clear keeps cc and top");
      step(6'b000000, 0, 0, 1, 0, 16'h003f, 0, 4'h0, 0, 3'd0, "R8 internal error all masked");
      step(6'b000010, 0, 0, 0, 1, 16'h003f, 0, 4'h0, 0, 3'd0, "R9 clear with same-cycle event");
      step(6'b000000, 0, 0, 0, 0, 16'h003d, 0, 4'h0, 0, 3'd0, "R3 R10 denormal unmasked");
      step(6'b000000, 1, 0, 0, 0, 16'h003d, 1, 4'b0010, 0, 3'd0, "R6 stack fault C1 beats cc write");
      step(6'b000000, 0, 0, 0, 0, 16'hffc0, 0, 4'h0, 0, 3'd0, "R11 R3 all unmasked upper bits set");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : watchdog
      #(20 * 5000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule